// File: doc/BRIEF.md
# Pause Loop Filter Counter

This block sits beside a processor core running a guest and decides when a burst of spin-wait pause instructions should hand control back to the hypervisor. When a guest is entered, it loads a pause budget and a 16-bit cycle threshold. It also measures the cycles between successive pause events. A pause that follows the previous event closely spends one unit of the budget. A pause that arrives after a long quiet stretch restores the budget in full.

When the budget runs out and interception is enabled, the block raises a one-cycle exit request. A threshold of zero switches off the spacing check, so every pause spends budget. After an exit the block stays quiet until the guest is entered again.

Top module: `pause_filter`

## Requirements
- R1: After reset `exitReq` is low, and no exit is raised before the first `enterGuest` pulse, whatever pauses arrive.
- R2: An `enterGuest` pulse loads the pause budget from `cfgCount`. A pause in the same cycle as `enterGuest` is ignored.
- R3: The spacing of a pause is the number of clock cycles since the previous pause or `enterGuest`, whichever came later. The first pause after entry is measured from the entry. The spacing counter is one bit wider than the threshold and saturates, so a gap longer than its range still counts as far apart.
- R4: With a nonzero `cfgThreshold`, a pause whose spacing is greater than the threshold reloads the budget from `cfgCount` and raises no exit.
- R5: A pause whose spacing is less than or equal to the threshold reduces the budget by one. A spacing exactly equal to the threshold counts as close.
- R6: With `cfgThreshold` equal to zero, every pause reduces the budget regardless of its spacing.
- R7: When a pause takes the budget below zero and `interceptEn` is high, `exitReq` is high for exactly one cycle, in the cycle after the pause is sampled. With budget N and only close pauses, the exit comes on pause number N+1.
- R8: While `interceptEn` is low, no exit is raised. The budget stays negative (held at minus one) until it is reloaded, so a later close pause with interception enabled exits at once.
- R9: After an exit, no further exit is raised until the next `enterGuest` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enterGuest | input | 1 | Guest entry strobe; loads the budget and arms the block |
| cfgCount | input | CNT_W | Pause budget |
| cfgThreshold | input | THR_W | Spacing threshold in cycles; zero selects count-only filtering |
| pauseEvt | input | 1 | Pause instruction event strobe |
| interceptEn | input | 1 | Allows exit requests |
| exitReq | output | 1 | One-cycle exit request |

## Verification
The budget and the spacing counter are hidden, so a fault in either shows at `exitReq` as an exit on the wrong pause, an exit missing, or a repeated exit. Such an error is visible in the cycle after the deciding pause. A spacing counter that is off by one is exposed by the pause sequences that land exactly on and just past the threshold. A spacing counter that wraps is exposed by a single gap longer than its range, which would wrongly lead to an exit. A missing floor on the budget is exposed by the test that disables and then re-enables interception.

// File: rtl/pause_filter_pkg.sv
package pause_filter_pkg;
  typedef struct packed {
    logic loadCnt;
    logic reloadCnt;
    logic decCnt;
    logic clrElapsed;
  } filtStrobes_t;
endpackage

// File: rtl/pause_filter_dp.sv
module pause_filter_dp
  import pause_filter_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int THR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  filtStrobes_t     ctrl,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic [THR_W-1:0] cfgThreshold,
  output logic             farApart,
  output logic             budgetDrains
);
  localparam int ELW = THR_W + 1;
  localparam int BW  = CNT_W + 1;
  localparam logic [ELW-1:0] EL_MAX = '1;

  logic [ELW-1:0] elapsed;
  logic [BW-1:0]  budget;
  logic           budgetNeg;

  assign budgetNeg = budget[BW-1];

  always_ff @(posedge clk) begin
    if (!rstN)                elapsed <= '0;
    else if (ctrl.clrElapsed) elapsed <= ELW'(1);
    else if (elapsed != EL_MAX) elapsed <= elapsed + ELW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      budget <= '0;
    else if (ctrl.loadCnt || ctrl.reloadCnt)
      budget <= {1'b0, cfgCount};
    else if (ctrl.decCnt && !budgetNeg)
      budget <= budget - BW'(1);
  end

  assign farApart     = (cfgThreshold != '0) && (elapsed > {1'b0, cfgThreshold});
  assign budgetDrains = budgetNeg || (budget == '0);

  a_r3_elapsed_saturates: assert property (@(posedge clk) disable iff (!rstN)
    (elapsed == EL_MAX && !ctrl.clrElapsed) |=> (elapsed == EL_MAX));
  a_r3_elapsed_counts: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clrElapsed |=> (elapsed == ELW'(1)));
  a_r2_load_budget: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadCnt |=> (budget == {1'b0, $past(cfgCount)}));
  a_r8_floor: assert property (@(posedge clk) disable iff (!rstN)
    budgetNeg |-> (budget == '1));
endmodule

// File: rtl/pause_filter_ctrl.sv
module pause_filter_ctrl
  import pause_filter_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enterGuest,
  input  logic         pauseEvt,
  input  logic         interceptEn,
  input  logic         farApart,
  input  logic         budgetDrains,
  output filtStrobes_t ctrl,
  output logic         exitReq
);
  logic armed;
  logic pauseTaken;
  logic fire;

  assign pauseTaken      = pauseEvt && !enterGuest;
  assign ctrl.loadCnt    = enterGuest;
  assign ctrl.clrElapsed = enterGuest || pauseEvt;
  assign ctrl.reloadCnt  = pauseTaken && farApart;
  assign ctrl.decCnt     = pauseTaken && !farApart;
  assign fire            = ctrl.decCnt && budgetDrains && interceptEn && armed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed   <= 1'b0;
      exitReq <= 1'b0;
    end else begin
      exitReq <= fire;
      if (enterGuest) armed <= 1'b1;
      else if (fire)  armed <= 1'b0;
    end
  end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    exitReq |=> !exitReq);
  a_r7_cause: assert property (@(posedge clk) disable iff (!rstN)
    exitReq |-> ($past(pauseEvt) && $past(interceptEn) && !$past(enterGuest)));
  a_r9_disarm: assert property (@(posedge clk) disable iff (!rstN)
    (exitReq && !enterGuest) |-> !armed);
  a_r1_unarmed_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && !enterGuest) |=> !exitReq);
endmodule

// File: rtl/pause_filter.sv
module pause_filter
  import pause_filter_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int THR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enterGuest,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic [THR_W-1:0] cfgThreshold,
  input  logic             pauseEvt,
  input  logic             interceptEn,
  output logic             exitReq
);
  filtStrobes_t ctrl;
  logic farApart;
  logic budgetDrains;

  pause_filter_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .enterGuest(enterGuest), .pauseEvt(pauseEvt),
    .interceptEn(interceptEn), .farApart(farApart), .budgetDrains(budgetDrains),
    .ctrl(ctrl), .exitReq(exitReq)
  );

  pause_filter_dp #(.CNT_W(CNT_W), .THR_W(THR_W)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .cfgCount(cfgCount),
    .cfgThreshold(cfgThreshold), .farApart(farApart), .budgetDrains(budgetDrains)
  );
endmodule

// File: tb/pause_filter_test.sv
module pause_filter_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enterGuest = 1'b0;
  logic [15:0] cfgCount = '0;
  logic [15:0] cfgThreshold = '0;
  logic        pauseEvt = 1'b0;
  logic        interceptEn = 1'b1;
  logic        exitReq;

  int checks = 0;
  int failures = 0;
  int idle = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pause_filter uut (
    .clk(clk), .rstN(rstN), .enterGuest(enterGuest), .cfgCount(cfgCount),
    .cfgThreshold(cfgThreshold), .pauseEvt(pauseEvt), .interceptEn(interceptEn),
    .exitReq(exitReq)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s exitReq=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    idle++;
  endtask

  task automatic enter(input logic [15:0] cnt, input logic [15:0] thr);
    cfgCount = cnt;
    cfgThreshold = thr;
    enterGuest = 1'b1;
    @(negedge clk);
    enterGuest = 1'b0;
    idle = 0;
  endtask

  // pause sampled exactly 'gap' cycles after the previous event; exitReq checked the cycle after
  task automatic pauseAt(input int gap, input logic expExit, input string req);
    while (idle < gap - 1) tick();
    pauseEvt = 1'b1;
    @(negedge clk);
    pauseEvt = 1'b0;
    idle = 0;
    check(exitReq, expExit, req);
  endtask

  task automatic testReset();
    check(exitReq, 1'b0, "R1 reset");
    cfgCount = 0; cfgThreshold = 0;
    pauseAt(3, 1'b0, "R1 no exit before entry");
    pauseAt(3, 1'b0, "R1 no exit before entry");
  endtask

  task automatic testCountOnly();
    enter(16'd2, 16'd0);
    pauseAt(200, 1'b0, "R6 count-only");
    pauseAt(200, 1'b0, "R6 count-only");
    pauseAt(200, 1'b1, "R6 R7 exit on third pause");
    tick();
    check(exitReq, 1'b0, "R7 pulse one cycle");
  endtask

  task automatic testThreshold();
    enter(16'd1, 16'd10);
    pauseAt(5, 1'b0, "R5 decrement");
    pauseAt(5, 1'b1, "R7 exit budget 1");
    enter(16'd1, 16'd10);
    pauseAt(5, 1'b0, "R5 decrement");
    pauseAt(20, 1'b0, "R4 far pause reloads");
    pauseAt(5, 1'b0, "R4 budget restored");
    pauseAt(5, 1'b1, "R4 exit after reload");
  endtask

  task automatic testEqual();
    enter(16'd0, 16'd10);
    pauseAt(11, 1'b0, "R3 R4 first pause measured from entry");
    pauseAt(10, 1'b1, "R5 equal spacing decrements");
  endtask

  task automatic testIntercept();
    interceptEn = 1'b0;
    enter(16'd0, 16'd0);
    pauseAt(3, 1'b0, "R8 intercept off");
    pauseAt(3, 1'b0, "R8 intercept off");
    interceptEn = 1'b1;
    pauseAt(3, 1'b1, "R8 budget held negative");
  endtask

  task automatic testRearm();
    enter(16'd0, 16'd0);
    pauseAt(3, 1'b1, "R9 first exit");
    pauseAt(3, 1'b0, "R9 quiet after exit");
    pauseAt(3, 1'b0, "R9 quiet after exit");
    enter(16'd0, 16'd0);
    pauseAt(3, 1'b1, "R9 rearmed by entry");
  endtask

  task automatic testSimultaneous();
    cfgCount = 16'd0;
    cfgThreshold = 16'd0;
    enterGuest = 1'b1;
    pauseEvt = 1'b1;
    @(negedge clk);
    enterGuest = 1'b0;
    pauseEvt = 1'b0;
    idle = 0;
    check(exitReq, 1'b0, "R2 pause with entry ignored");
    pauseAt(3, 1'b1, "R2 budget loaded intact");
  endtask

  task automatic testSaturation();
    enter(16'd0, 16'hFFFF);
    pauseAt(132000, 1'b0, "R3 saturated gap is far");
    pauseAt(5, 1'b1, "R3 exit after reload");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCountOnly();
    testThreshold();
    testEqual();
    testIntercept();
    testRearm();
    testSimultaneous();
    testSaturation();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule